// File: doc/BRIEF.md
# Flash Row Programming Sequencer

This block turns a request of the form "write these bytes starting here" into the sequence of serial programming transactions that a flash microcontroller's in-circuit programming port expects. It sits above a bit-level command engine. It hands that engine one request at a time through a valid/ready pair. Each request is one of four kinds: a 4-bit command with a 16-bit operand, a run of zero bits, a clock-high programming pulse, or a plain wait. Byte data arrives on a separate valid/ready stream.

Flash is programmed in whole rows of 64 bytes. The sequencer rounds the start address down to a row boundary. It covers the span up to the next row boundary past the last byte, and fills every position that is not user data with 0xFF. For each row it loads the 22-bit table pointer, streams the row as 32 two-byte words, and then closes the row with the programming pulse sequence. A second entry point issues the whole-device erase sequence. A one-cycle completion pulse marks the end of either operation.

Top module: `fws_row_writer`

## Requirements
- R1: While reset is held and right after it, `req_valid`, `in_ready` and `done` are low.
- R2: A write of nonzero length starts with exactly one command request of code 0x0 and operand 0x84A6, which enables writing.
- R3: Each row starts with six code-0x0 requests that load the table pointer. They carry the operands {0x0E, upper}, {0x6E, 0xF8}, {0x0E, high}, {0x6E, 0xF7}, {0x0E, low}, {0x6E, 0xF6}, where upper/high/low are bits 23:16, 15:8 and 7:0 of the row base. The first row base is the start address rounded down to a multiple of 64, and each later row adds 64.
- R4: After the pointer load come 32 data requests. The first 31 use code 0xD and the 32nd uses code 0xF. Operand bits 7:0 hold the lower-addressed byte of the pair and bits 15:8 the higher one.
- R5: The number of rows is ceil((offset + length) / 64), where offset is the start address modulo 64. Positions before the offset and after the last data byte read as 0xFF.
- R6: After the 0xF request of every row come, in order: 3 zero bits, a programming pulse of PROG_CYC cycles, a wait of GAP_CYC cycles, and 16 zero bits. Request kinds are encoded 0 = command, 1 = zero bits (count in `req_bits`), 2 = pulse, 3 = wait (length in `req_cycles`).
- R7: `in_ready` is raised only for real data positions. A write consumes exactly `wr_len` bytes, in address order, and never raises `in_ready` while idle.
- R8: Bulk erase issues six pointer-load requests for 0x3C0005, code 0xC with 0x0101, six pointer-load requests for 0x3C0004, code 0xC with 0x8080, code 0x0 with 0x0000, 4 zero bits, a wait of ERASE_CYC cycles, and 16 zero bits.
- R9: `done` pulses for one cycle, in the cycle after the last request handshake. A write of length 0 raises `done` in the cycle after the start, with no requests and no bytes consumed.
- R10: While `req_valid` is high and `req_ready` is low, the request stays valid and all its fields stay unchanged.
- R11: Start inputs are ignored while an operation runs. If both starts arrive together while idle, the erase runs and the write is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_wr | input | 1 | Start a row write of `wr_len` bytes at `wr_addr` |
| start_erase | input | 1 | Start a bulk erase |
| wr_addr | input | ADDR_W | Byte address of the first data byte |
| wr_len | input | LEN_W | Number of data bytes |
| in_valid | input | 1 | Data byte available |
| in_ready | output | 1 | Data byte taken this cycle |
| in_data | input | 8 | Data byte |
| req_valid | output | 1 | Request to the command engine is valid |
| req_ready | input | 1 | Engine accepts the request |
| req_kind | output | 2 | 0 command, 1 zero bits, 2 pulse, 3 wait |
| req_code | output | 4 | 4-bit command code |
| req_data | output | 16 | Command operand |
| req_bits | output | 5 | Zero-bit count |
| req_cycles | output | CYC_W | Pulse or wait length in clock cycles |
| done | output | 1 | One-cycle completion pulse |

## Verification
Two starts can land in the same cycle. The bench drives `start_wr` and `start_erase` together while idle and expects the erase sequence, with no data bytes pulled. It also raises both starts in the middle of a running write, and expects that write's request log to match the model exactly, with a single `done`. The request log, the count of bytes consumed and the timing of `done` are compared against a model built from the requirements. The engine's ready and the stream's valid toggle with different periods throughout.

// File: rtl/fws_pkg.sv
`timescale 1ns/1ps
package fws_pkg;

    typedef enum logic [1:0] {
        RQ_CMD   = 2'd0,
        RQ_ZEROS = 2'd1,
        RQ_PULSE = 2'd2,
        RQ_WAIT  = 2'd3
    } rq_kind_e;

    typedef struct packed {
        rq_kind_e    kind;
        logic [3:0]  code;
        logic [15:0] data;
        logic [4:0]  nbits;
    } rq_t;

    typedef enum logic [3:0] {
        S_IDLE   = 4'd0,
        S_WREN   = 4'd1,
        S_PTR    = 4'd2,
        S_WORD   = 4'd3,
        S_GAP3   = 4'd4,
        S_PULSE  = 4'd5,
        S_SETTLE = 4'd6,
        S_TAIL   = 4'd7,
        S_ERASE  = 4'd8
    } st_e;

    localparam logic [3:0]  OP_CORE     = 4'h0;
    localparam logic [3:0]  OP_TWR      = 4'hC;
    localparam logic [3:0]  OP_TWR_INC2 = 4'hD;
    localparam logic [3:0]  OP_TWR_GO   = 4'hF;

    localparam logic [7:0]  INS_LIT     = 8'h0E;
    localparam logic [7:0]  INS_STORE   = 8'h6E;
    localparam logic [7:0]  RG_PTR_U    = 8'hF8;
    localparam logic [7:0]  RG_PTR_H    = 8'hF7;
    localparam logic [7:0]  RG_PTR_L    = 8'hF6;

    localparam logic [15:0] WREN_WORD   = 16'h84A6;
    localparam logic [23:0] ER_ADDR_A   = 24'h3C0005;
    localparam logic [23:0] ER_ADDR_B   = 24'h3C0004;
    localparam logic [15:0] ER_VAL_A    = 16'h0101;
    localparam logic [15:0] ER_VAL_B    = 16'h8080;

    // Operand for step k (0..5) of a table pointer load: literal then store,
    // upper byte first.
    function automatic logic [15:0] ptr_load(input logic [23:0] a, input logic [2:0] k);
        case (k)
            3'd0:    return {INS_LIT, a[23:16]};
            3'd1:    return {INS_STORE, RG_PTR_U};
            3'd2:    return {INS_LIT, a[15:8]};
            3'd3:    return {INS_STORE, RG_PTR_H};
            3'd4:    return {INS_LIT, a[7:0]};
            default: return {INS_STORE, RG_PTR_L};
        endcase
    endfunction

endpackage

// File: rtl/fws_span.sv
`timescale 1ns/1ps
module fws_span #(
    parameter int ADDR_W  = 22,
    parameter int LEN_W   = 16,
    parameter int ROW_LG2 = 6,
    parameter int ROWS_W  = 12
) (
    input  logic [ADDR_W-1:0]  addr,
    input  logic [LEN_W-1:0]   len,
    output logic [ADDR_W-1:0]  base,
    output logic [ROW_LG2-1:0] off,
    output logic [ROWS_W-1:0]  rows
);
    localparam int SUM_W = LEN_W + 1;

    logic [SUM_W-1:0] sum;

    assign off  = addr[ROW_LG2-1:0];
    assign base = {addr[ADDR_W-1:ROW_LG2], {ROW_LG2{1'b0}}};
    assign sum  = SUM_W'(off) + SUM_W'(len) + SUM_W'((1 << ROW_LG2) - 1);
    assign rows = ROWS_W'(sum >> ROW_LG2);
endmodule

// File: rtl/fws_erase_rom.sv
`timescale 1ns/1ps
module fws_erase_rom
    import fws_pkg::*;
#(
    parameter int STEP_W = 5
) (
    input  logic [STEP_W-1:0] step,
    output rq_t               rq,
    output logic              is_wait,
    output logic              is_last
);
    logic [STEP_W-1:0] rel;

    always_comb begin
        rq      = '0;
        rq.kind = RQ_CMD;
        rq.code = OP_CORE;
        is_wait = 1'b0;
        is_last = 1'b0;
        rel     = step - STEP_W'(7);
        if (step <= STEP_W'(5)) begin
            rq.data = ptr_load(ER_ADDR_A, step[2:0]);
        end else if (step == STEP_W'(6)) begin
            rq.code = OP_TWR;
            rq.data = ER_VAL_A;
        end else if (step <= STEP_W'(12)) begin
            rq.data = ptr_load(ER_ADDR_B, rel[2:0]);
        end else if (step == STEP_W'(13)) begin
            rq.code = OP_TWR;
            rq.data = ER_VAL_B;
        end else if (step == STEP_W'(14)) begin
            rq.data = 16'h0000;
        end else if (step == STEP_W'(15)) begin
            rq.kind  = RQ_ZEROS;
            rq.nbits = 5'd4;
        end else if (step == STEP_W'(16)) begin
            rq.kind = RQ_WAIT;
            is_wait = 1'b1;
        end else begin
            rq.kind  = RQ_ZEROS;
            rq.nbits = 5'd16;
            is_last  = 1'b1;
        end
    end
endmodule

// File: rtl/fws_packer.sv
`timescale 1ns/1ps
module fws_packer #(
    parameter int LEN_W   = 16,
    parameter int ROW_LG2 = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic [ROW_LG2-1:0] skip_in,
    input  logic [LEN_W-1:0]   len_in,
    input  logic               take,
    input  logic               in_valid,
    input  logic [7:0]         in_data,
    output logic               in_ready,
    output logic               word_valid,
    output logic [15:0]        word
);
    typedef struct packed {
        logic [ROW_LG2-1:0] skip;
        logic [LEN_W-1:0]   left;
        logic [7:0]         lo;
        logic               ph;
        logic               full;
        logic [15:0]        word;
    } pk_t;

    pk_t        pk_q, pk_d;
    logic       got;
    logic [7:0] b;

    always_comb begin
        pk_d     = pk_q;
        in_ready = 1'b0;
        got      = 1'b0;
        b        = 8'hFF;
        if (start) begin
            pk_d.skip = skip_in;
            pk_d.left = len_in;
            pk_d.ph   = 1'b0;
            pk_d.full = 1'b0;
        end else if (pk_q.full) begin
            if (take) pk_d.full = 1'b0;
        end else begin
            if (pk_q.skip != '0) begin
                got       = 1'b1;
                pk_d.skip = pk_q.skip - ROW_LG2'(1);
            end else if (pk_q.left != '0) begin
                in_ready = 1'b1;
                got      = in_valid;
                b        = in_data;
                if (in_valid) pk_d.left = pk_q.left - LEN_W'(1);
            end else begin
                got = 1'b1;
            end
            if (got) begin
                if (!pk_q.ph) begin
                    pk_d.lo = b;
                    pk_d.ph = 1'b1;
                end else begin
                    pk_d.word = {b, pk_q.lo};
                    pk_d.full = 1'b1;
                    pk_d.ph   = 1'b0;
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) pk_q <= '0;
        else        pk_q <= pk_d;
    end

    assign word_valid = pk_q.full;
    assign word       = pk_q.word;

    // R4
    word_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (word_valid && !take && !start) |=> (word_valid && $stable(word)));
endmodule

// File: rtl/fws_row_writer.sv
`timescale 1ns/1ps
module fws_row_writer
    import fws_pkg::*;
#(
    parameter int ADDR_W    = 22,
    parameter int LEN_W     = 16,
    parameter int ROW_LG2   = 6,
    parameter int CYC_W     = 27,
    parameter int PROG_CYC  = 240000,
    parameter int GAP_CYC   = 200,
    parameter int ERASE_CYC = 115600000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_wr,
    input  logic              start_erase,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [LEN_W-1:0]  wr_len,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [7:0]        in_data,
    output logic              req_valid,
    input  logic              req_ready,
    output logic [1:0]        req_kind,
    output logic [3:0]        req_code,
    output logic [15:0]       req_data,
    output logic [4:0]        req_bits,
    output logic [CYC_W-1:0]  req_cycles,
    output logic              done
);
    localparam int ROW_BYTES = 1 << ROW_LG2;
    localparam int ROW_WORDS = ROW_BYTES / 2;
    localparam int ROWS_W    = LEN_W - ROW_LG2 + 2;
    localparam int STEP_W    = (ROW_LG2 - 1 > 5) ? ROW_LG2 - 1 : 5;

    typedef struct packed {
        st_e               st;
        logic [STEP_W-1:0] step;
        logic [ROWS_W-1:0] rows_left;
        logic [ADDR_W-1:0] row_addr;
        logic              vld;
        rq_t               rq;
        logic [CYC_W-1:0]  cyc;
        logic              done;
    } ctl_t;

    ctl_t ctl_q, ctl_d;

    logic [ADDR_W-1:0]  sp_base;
    logic [ROW_LG2-1:0] sp_off;
    logic [ROWS_W-1:0]  sp_rows;
    logic               pk_start, pk_take, pk_valid;
    logic [15:0]        pk_word;
    rq_t                er_rq;
    logic               er_wait, er_last;
    rq_t                pl;
    logic [CYC_W-1:0]   pl_cyc;
    logic               load_ok;
    logic [23:0]        ptr_ext;

    fws_span #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W), .ROW_LG2 (ROW_LG2), .ROWS_W (ROWS_W)
    ) u_span (
        .addr (wr_addr), .len (wr_len),
        .base (sp_base), .off (sp_off), .rows (sp_rows)
    );

    fws_packer #(
        .LEN_W (LEN_W), .ROW_LG2 (ROW_LG2)
    ) u_packer (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (pk_start),
        .skip_in    (sp_off),
        .len_in     (wr_len),
        .take       (pk_take),
        .in_valid   (in_valid),
        .in_data    (in_data),
        .in_ready   (in_ready),
        .word_valid (pk_valid),
        .word       (pk_word)
    );

    fws_erase_rom #(
        .STEP_W (STEP_W)
    ) u_erase (
        .step    (ctl_q.step),
        .rq      (er_rq),
        .is_wait (er_wait),
        .is_last (er_last)
    );

    assign ptr_ext  = 24'(ctl_q.row_addr);
    assign pk_start = (ctl_q.st == S_IDLE) && start_wr && !start_erase && (wr_len != '0);

    always_comb begin
        ctl_d      = ctl_q;
        ctl_d.done = 1'b0;
        pk_take    = 1'b0;
        pl         = '0;
        pl.kind    = RQ_CMD;
        pl.code    = OP_CORE;
        pl_cyc     = '0;
        load_ok    = 1'b1;

        case (ctl_q.st)
            S_WREN:   pl.data = WREN_WORD;
            S_PTR:    pl.data = ptr_load(ptr_ext, ctl_q.step[2:0]);
            S_WORD: begin
                pl.code = (ctl_q.step == STEP_W'(ROW_WORDS - 1)) ? OP_TWR_GO : OP_TWR_INC2;
                pl.data = pk_word;
                load_ok = pk_valid;
            end
            S_GAP3: begin
                pl.kind  = RQ_ZEROS;
                pl.nbits = 5'd3;
            end
            S_PULSE: begin
                pl.kind = RQ_PULSE;
                pl_cyc  = CYC_W'(PROG_CYC);
            end
            S_SETTLE: begin
                pl.kind = RQ_WAIT;
                pl_cyc  = CYC_W'(GAP_CYC);
            end
            S_TAIL: begin
                pl.kind  = RQ_ZEROS;
                pl.nbits = 5'd16;
            end
            S_ERASE: begin
                pl     = er_rq;
                pl_cyc = er_wait ? CYC_W'(ERASE_CYC) : '0;
            end
            default: ;
        endcase

        if (ctl_q.st == S_IDLE) begin
            if (start_erase) begin
                ctl_d.st   = S_ERASE;
                ctl_d.step = '0;
            end else if (start_wr) begin
                if (wr_len == '0) begin
                    ctl_d.done = 1'b1;
                end else begin
                    ctl_d.st        = S_WREN;
                    ctl_d.row_addr  = sp_base;
                    ctl_d.rows_left = sp_rows;
                end
            end
        end else if (!ctl_q.vld) begin
            if (load_ok) begin
                ctl_d.vld = 1'b1;
                ctl_d.rq  = pl;
                ctl_d.cyc = pl_cyc;
                pk_take   = (ctl_q.st == S_WORD);
            end
        end else if (req_ready) begin
            ctl_d.vld = 1'b0;
            case (ctl_q.st)
                S_WREN: begin
                    ctl_d.st   = S_PTR;
                    ctl_d.step = '0;
                end
                S_PTR: begin
                    if (ctl_q.step == STEP_W'(5)) begin
                        ctl_d.st   = S_WORD;
                        ctl_d.step = '0;
                    end else begin
                        ctl_d.step = ctl_q.step + STEP_W'(1);
                    end
                end
                S_WORD: begin
                    if (ctl_q.step == STEP_W'(ROW_WORDS - 1)) ctl_d.st = S_GAP3;
                    else ctl_d.step = ctl_q.step + STEP_W'(1);
                end
                S_GAP3:   ctl_d.st = S_PULSE;
                S_PULSE:  ctl_d.st = S_SETTLE;
                S_SETTLE: ctl_d.st = S_TAIL;
                S_TAIL: begin
                    if (ctl_q.rows_left == ROWS_W'(1)) begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.rows_left = ctl_q.rows_left - ROWS_W'(1);
                        ctl_d.row_addr  = ctl_q.row_addr + ADDR_W'(ROW_BYTES);
                        ctl_d.st        = S_PTR;
                        ctl_d.step      = '0;
                    end
                end
                S_ERASE: begin
                    if (er_last) begin
                        ctl_d.st   = S_IDLE;
                        ctl_d.done = 1'b1;
                    end else begin
                        ctl_d.step = ctl_q.step + STEP_W'(1);
                    end
                end
                default: ctl_d.st = S_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    assign req_valid  = ctl_q.vld;
    assign req_kind   = ctl_q.rq.kind;
    assign req_code   = ctl_q.rq.code;
    assign req_data   = ctl_q.rq.data;
    assign req_bits   = ctl_q.rq.nbits;
    assign req_cycles = ctl_q.cyc;
    assign done       = ctl_q.done;

    // R10
    req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && !req_ready) |=>
        (req_valid && $stable({req_kind, req_code, req_data, req_bits, req_cycles})));

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctl_q.st == S_IDLE) |-> (!req_valid && !in_ready));

    // R6
    go_then_gap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && req_kind == 2'd0 && req_code == OP_TWR_GO) |=>
        (ctl_q.st == S_GAP3));

    // R9
    done_after_hs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(ctl_q.st != S_IDLE)) |-> $past(req_valid && req_ready));
endmodule

// File: tb/fws_row_writer_tb.sv
`timescale 1ns/1ps
module fws_row_writer_tb;
    localparam int ADDR_W    = 22;
    localparam int LEN_W     = 16;
    localparam int CYC_W     = 27;
    localparam int PROG_CYC  = 240000;     // 1.2 ms at 200 MHz
    localparam int GAP_CYC   = 200;        // 1 us
    localparam int ERASE_CYC = 115600000;  // 578 ms
    localparam int EW        = 2 + 4 + 16 + 5 + CYC_W;
    localparam int NV        = 6;

    // {address, length, seed}
    localparam logic [45:0] VEC [NV] = '{
        {22'h000040, 16'd64,  8'h11},
        {22'h000105, 16'd10,  8'h22},
        {22'h0003F0, 16'd40,  8'h33},
        {22'h012345, 16'd130, 8'h44},
        {22'h3FFFC0, 16'd64,  8'h55},
        {22'h000000, 16'd1,   8'h66}
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              start_wr = 1'b0, start_erase = 1'b0;
    logic [ADDR_W-1:0] wr_addr = '0;
    logic [LEN_W-1:0]  wr_len = '0;
    logic              in_valid = 1'b0, in_ready;
    logic [7:0]        in_data = 8'h00;
    logic              req_valid, req_ready = 1'b0;
    logic [1:0]        req_kind;
    logic [3:0]        req_code;
    logic [15:0]       req_data;
    logic [4:0]        req_bits;
    logic [CYC_W-1:0]  req_cycles;
    logic              done;

    always #2.5 clk = ~clk;

    fws_row_writer #(
        .ADDR_W (ADDR_W), .LEN_W (LEN_W), .ROW_LG2 (6), .CYC_W (CYC_W),
        .PROG_CYC (PROG_CYC), .GAP_CYC (GAP_CYC), .ERASE_CYC (ERASE_CYC)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .start_wr (start_wr), .start_erase (start_erase),
        .wr_addr (wr_addr), .wr_len (wr_len), .in_valid (in_valid), .in_ready (in_ready),
        .in_data (in_data), .req_valid (req_valid), .req_ready (req_ready),
        .req_kind (req_kind), .req_code (req_code), .req_data (req_data),
        .req_bits (req_bits), .req_cycles (req_cycles), .done (done)
    );

    logic [EW-1:0] got_q [512];
    logic [EW-1:0] exp_q [512];
    string         exp_tag [512];
    int            n_got = 0, n_exp = 0;
    int            cyc = 0, last_hs_cyc = -1, done_cyc = -1, start_cyc = -1;
    int            done_cnt = 0, bytes_taken = 0;
    int            n_checks = 0, n_fail = 0;
    logic [7:0]    seed = 8'h00;

    function automatic logic [7:0] src_byte(input int k);
        return 8'(k * 29 + int'(seed) * 7 + 3);
    endfunction

    function automatic logic [EW-1:0] e_cmd(input logic [3:0] c, input logic [15:0] d);
        return {2'd0, c, d, 5'd0, CYC_W'(0)};
    endfunction
    function automatic logic [EW-1:0] e_zero(input int n);
        return {2'd1, 4'd0, 16'd0, 5'(n), CYC_W'(0)};
    endfunction
    function automatic logic [EW-1:0] e_pulse(input int c);
        return {2'd2, 4'd0, 16'd0, 5'd0, CYC_W'(c)};
    endfunction
    function automatic logic [EW-1:0] e_wait(input int c);
        return {2'd3, 4'd0, 16'd0, 5'd0, CYC_W'(c)};
    endfunction

    function automatic logic [15:0] tb_ptr(input logic [23:0] a, input int k);
        case (k)
            0: return {8'h0E, a[23:16]};
            1: return 16'h6EF8;
            2: return {8'h0E, a[15:8]};
            3: return 16'h6EF7;
            4: return {8'h0E, a[7:0]};
            default: return 16'h6EF6;
        endcase
    endfunction

    task automatic push(input logic [EW-1:0] e, input string tag);
        exp_q[n_exp] = e;
        exp_tag[n_exp] = tag;
        n_exp++;
    endtask

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] span_byte(input int p, input int off, input int len);
        if (p >= off && p < off + len) return src_byte(p - off);
        return 8'hFF;
    endfunction

    task automatic build_write(input logic [21:0] a, input int len);
        int          off, rows;
        logic [23:0] ra;
        logic [7:0]  lo, hi;
        n_exp = 0;
        if (len == 0) return;
        off  = int'(a[5:0]);
        rows = (off + len + 63) / 64;
        push(e_cmd(4'h0, 16'h84A6), "R2");
        for (int r = 0; r < rows; r++) begin
            ra = 24'({a[21:6], 6'd0}) + 24'(r * 64);
            for (int k = 0; k < 6; k++) push(e_cmd(4'h0, tb_ptr(ra, k)), "R3");
            for (int w = 0; w < 32; w++) begin
                lo = span_byte(r * 64 + 2 * w, off, len);
                hi = span_byte(r * 64 + 2 * w + 1, off, len);
                push(e_cmd((w == 31) ? 4'hF : 4'hD, {hi, lo}), "R4/R5");
            end
            push(e_zero(3), "R6");
            push(e_pulse(PROG_CYC), "R6");
            push(e_wait(GAP_CYC), "R6");
            push(e_zero(16), "R6");
        end
    endtask

    task automatic build_erase();
        n_exp = 0;
        for (int k = 0; k < 6; k++) push(e_cmd(4'h0, tb_ptr(24'h3C0005, k)), "R8");
        push(e_cmd(4'hC, 16'h0101), "R8");
        for (int k = 0; k < 6; k++) push(e_cmd(4'h0, tb_ptr(24'h3C0004, k)), "R8");
        push(e_cmd(4'hC, 16'h8080), "R8");
        push(e_cmd(4'h0, 16'h0000), "R8");
        push(e_zero(4), "R8");
        push(e_wait(ERASE_CYC), "R8");
        push(e_zero(16), "R8");
    endtask

    // Monitor and engine/stream model: sample mid-cycle, drive after the edge.
    always begin
        @(negedge clk);
        cyc++;
        if (req_valid && req_ready) begin
            if (n_got < 512) got_q[n_got] = {req_kind, req_code, req_data, req_bits, req_cycles};
            n_got++;
            last_hs_cyc = cyc;
        end
        if (in_valid && in_ready) bytes_taken++;
        if (done) begin
            done_cnt++;
            done_cyc = cyc;
        end
        if ((start_wr || start_erase) && start_cyc < 0) start_cyc = cyc;
        @(posedge clk);
        #1;
        req_ready = (cyc % 3) != 1;
        in_valid  = (cyc % 5) != 3;
        in_data   = src_byte(bytes_taken);
    end

    // Watchdog
    always begin
        @(negedge clk);
        if (cyc > 150000) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual %0d expected below 150000 cycles", cyc);
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

    task automatic run_op(input bit w, input bit e, input logic [21:0] a,
                          input logic [15:0] l, input bit poke);
        int guard;
        n_got = 0; bytes_taken = 0; done_cnt = 0;
        last_hs_cyc = -1; done_cyc = -1; start_cyc = -1;
        @(posedge clk); #1;
        wr_addr = a; wr_len = l; start_wr = w; start_erase = e;
        @(posedge clk); #1;
        start_wr = 1'b0; start_erase = 1'b0;
        if (poke) begin
            repeat (20) @(posedge clk);
            #1;
            wr_addr = 22'h000200; wr_len = 16'd5; start_wr = 1'b1; start_erase = 1'b1;
            @(posedge clk); #1;
            start_wr = 1'b0; start_erase = 1'b0;
        end
        guard = 0;
        while (done_cnt == 0 && guard < 5000) begin
            @(posedge clk);
            guard++;
        end
        repeat (12) @(posedge clk);
        #1;
    endtask

    task automatic verify(input string tag, input int exp_bytes);
        chk(n_got == n_exp, {tag, " request count"}, n_got, n_exp);
        for (int i = 0; i < n_exp && i < n_got; i++)
            chk(got_q[i] == exp_q[i], exp_tag[i], got_q[i], exp_q[i]);
        chk(bytes_taken == exp_bytes, "R7 bytes consumed", bytes_taken, exp_bytes);
        chk(done_cnt == 1, "R9 done count", done_cnt, 1);
        if (n_exp > 0) chk(done_cyc == last_hs_cyc + 1, "R9 done timing", done_cyc, last_hs_cyc + 1);
        else           chk(done_cyc == start_cyc + 1, "R9 zero-length done", done_cyc, start_cyc + 1);
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!req_valid && !in_ready && !done, "R1 in reset", {req_valid, in_ready, done}, 0);
        @(posedge clk); #1;
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        chk(!req_valid && !in_ready && !done, "R1 after reset", {req_valid, in_ready, done}, 0);

        // Table of write cases: R2..R7, R9, R10 under stalls
        for (int i = 0; i < NV; i++) begin
            seed = VEC[i][7:0];
            build_write(VEC[i][45:24], int'(VEC[i][23:8]));
            run_op(1'b1, 1'b0, VEC[i][45:24], VEC[i][23:8], 1'b0);
            verify("R5 table case", int'(VEC[i][23:8]));
        end

        // R8 bulk erase alone
        build_erase();
        run_op(1'b0, 1'b1, 22'h000000, 16'd0, 1'b0);
        verify("R8 erase", 0);

        // R11 both starts together: erase wins, no bytes pulled
        seed = 8'h77;
        build_erase();
        run_op(1'b1, 1'b1, 22'h000080, 16'd20, 1'b0);
        verify("R11 collision", 0);

        // R11 starts during a running write are ignored
        seed = 8'h88;
        build_write(22'h000123, 70);
        run_op(1'b1, 1'b0, 22'h000123, 16'd70, 1'b1);
        verify("R11 busy start", 70);

        // R9 zero length
        build_write(22'h000010, 0);
        run_op(1'b1, 1'b0, 22'h000010, 16'd0, 1'b0);
        verify("R9 zero length", 0);

        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end
endmodule